// File: doc/BRIEF.md
# Serial Flash Pin-Interface Front End

This block is the device-side pin logic of a serial NOR flash. It watches the host's chip select, serial clock and four data pins, and turns the serial traffic into whole bytes with a valid strobe for the flash core. In the other direction it takes bytes from the core and shifts them back out. All pins are oversampled by the block's own clock through a short synchronizer, so the whole block runs in one clock domain and acts on the detected rising and falling edges of the serial clock.

Two transfer widths are supported. In one-bit mode, data enters on lane 0 and leaves on lane 1. In four-bit mode, all four lanes carry a nibble per serial clock edge. Lanes 2 and 3 normally serve as the write-protect and hold inputs. When the core's quad-enable bit is set, they become ordinary data lanes. The core selects the width and direction of the following bytes through two level inputs. These are sampled at the serial clock edge that completes each byte. A request for four-bit transfer while quad-enable is clear drops the rest of the transaction. The block also gives the core a lock flag that blocks status register writes.

Top module: `sflash_pin_front`

## Requirements
- R1: In one-bit mode, each rising serial clock edge shifts lane 0 in, most significant bit first. After eight edges, `rx_valid_o` pulses for one clock with the byte on `rx_byte_o`. `rx_first_o` is 1 only for the first byte of a transaction.
- R2: While four-bit mode is selected, each rising edge shifts in one nibble, most significant nibble first, with lane 3 as the highest bit. Four-bit mode can only be entered when `quad_en_i` is 1.
- R3: If `ph_quad_i` is 1 while `quad_en_i` is 0 when a byte completes, the transaction is dropped. No further `rx_valid_o` pulses and no output enables occur until chip select goes high.
- R4: In the data-out phase, output lanes change only after a falling serial clock edge. One-bit data leaves on lane 1, MSB first. Four-bit data leaves as nibbles on lanes 3..0, high nibble first. `tx_req_o` pulses once each time a byte is taken from `tx_data_i`.
- R5: `dq_oe_o` is 4'b0010 in a one-bit data-out phase and 4'b1111 in a four-bit one. It is 0 at all other times, including whenever chip select is high.
- R6: After reset, no byte is received until chip select has been seen going from high to low.
- R7: Chip select going high aborts the transfer. A partial byte is discarded, and the next transaction starts at bit 0 with `rx_first_o` set on its first byte.
- R8: With `quad_en_i` 0, lane 3 low while selected is a hold. During a hold, serial clock edges are ignored, the output lanes freeze, and `dq_oe_o` is 0. The transfer resumes at the same bit when lane 3 returns high.
- R9: With `quad_en_i` 1, lane 3 low does not hold, and lane 2 has no write-protect effect.
- R10: `sr_lock_o` is 1 exactly when `srp_i` is 1, `quad_en_i` is 0 and lane 2 (write-protect, active low) is 0, after synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| dq_i | input | DQ_W | Data lane inputs; lane 2 is write-protect and lane 3 is hold when quad-enable is clear |
| dq_o | output | DQ_W | Data lane output values |
| dq_oe_o | output | DQ_W | Per-lane output enable |
| quad_en_i | input | 1 | Quad-enable bit from the core's status register |
| srp_i | input | 1 | Status register protect bit from the core |
| ph_quad_i | input | 1 | Core request: following bytes use four lanes |
| ph_out_i | input | 1 | Core request: following bytes are driven out |
| rx_byte_o | output | BYTE_W | Received byte |
| rx_valid_o | output | 1 | One-clock strobe for `rx_byte_o` |
| rx_first_o | output | 1 | Received byte is the first of the transaction |
| tx_data_i | input | BYTE_W | Next byte to drive out |
| tx_req_o | output | 1 | Pulse: `tx_data_i` was taken |
| sr_lock_o | output | 1 | Status register writes are blocked |

## Verification
Several byte patterns are sent: one-bit streams, nibble streams that switch width after the instruction byte, and reads in both widths. Together they distinguish bit order, nibble order and lane placement, and the reads show the output moves only on falling edges. Aborted partial bytes and a chip select held low through reset show whether the shift state is cleared and whether arming is needed. Holds placed mid-byte on input and output, the same pin pattern with quad-enable set, and a four-bit request with quad-enable clear separate hold, pin repurposing and rejection. Every combination of the protect inputs checks the lock flag.

// File: rtl/sflash_pin_pkg.sv
package sflash_pin_pkg;

  // Transaction phase after the instruction byte.
  typedef enum logic [1:0] {
    PH_IN   = 2'd0,
    PH_OUT  = 2'd1,
    PH_DROP = 2'd2
  } xfer_phase_e;

endpackage

// File: rtl/sflash_pin_sync.sv
module sflash_pin_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        stg_q[i] <= stg_q[i-1];
      end
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sflash_rx_shift.sv
module sflash_rx_shift #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              quad_i,
  input  logic [LANES-1:0]  lanes_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W:0] STEP_ONE  = 1;
  localparam logic [CNT_W:0] STEP_QUAD = LANES;
  localparam logic [CNT_W:0] FULL      = BYTE_W;

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    sum;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    sum    = '0;
    if (clr_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (step_i) begin
      if (quad_i) begin
        sh_d = {sh_q[BYTE_W-LANES-1:0], lanes_i};
        sum  = {1'b0, cnt_q} + STEP_QUAD;
      end else begin
        sh_d = {sh_q[BYTE_W-2:0], lanes_i[0]};
        sum  = {1'b0, cnt_q} + STEP_ONE;
      end
      done_o = (sum >= FULL);
      cnt_d  = done_o ? '0 : sum[CNT_W-1:0];
    end
  end

  assign byte_o = sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: a nibble step only ever starts on a nibble boundary of the byte
  a_r2_nibble_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && quad_i && !clr_i) |-> ((int'(cnt_q) % LANES) == 0));

endmodule

// File: rtl/sflash_tx_shift.sv
module sflash_tx_shift #(
  parameter int BYTE_W  = 8,
  parameter int LANES   = 4,
  parameter int SO_LANE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              quad_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              load_o,
  output logic [LANES-1:0]  lanes_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W:0] STEP_ONE  = 1;
  localparam logic [CNT_W:0] STEP_QUAD = LANES;
  localparam logic [CNT_W:0] FULL      = BYTE_W;

  logic [BYTE_W-1:0] buf_q, buf_d, src;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LANES-1:0]  out_q, out_d;
  logic [CNT_W:0]    sum;

  always_comb begin
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    load_o = 1'b0;
    sum    = '0;
    src    = buf_q;
    if (clr_i) begin
      buf_d = '0;
      cnt_d = '0;
      out_d = '0;
    end else if (step_i) begin
      if (cnt_q == '0) begin
        src    = data_i;
        load_o = 1'b1;
      end
      if (quad_i) begin
        out_d = src[BYTE_W-1 -: LANES];
        buf_d = src << LANES;
        sum   = {1'b0, cnt_q} + STEP_QUAD;
      end else begin
        out_d          = '0;
        out_d[SO_LANE] = src[BYTE_W-1];
        buf_d          = src << 1;
        sum            = {1'b0, cnt_q} + STEP_ONE;
      end
      cnt_d = (sum >= FULL) ? '0 : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
      out_q <= '0;
    end else begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign lanes_o = out_q;

endmodule

// File: rtl/sflash_pin_front.sv
module sflash_pin_front
  import sflash_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int DQ_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [DQ_W-1:0]   dq_oe_o,
  input  logic              quad_en_i,
  input  logic              srp_i,
  input  logic              ph_quad_i,
  input  logic              ph_out_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_req_o,
  output logic              sr_lock_o
);

  localparam int HOLD_LANE = DQ_W - 1;
  localparam int WP_LANE   = 2;
  localparam int SO_LANE   = 1;
  localparam int PIN_W     = DQ_W + 2;
  localparam logic [DQ_W-1:0]  DQ_RST  = DQ_W'((1 << HOLD_LANE) | (1 << WP_LANE));
  localparam logic [PIN_W-1:0] PIN_RST = {2'b00, DQ_RST};
  localparam logic [DQ_W-1:0]  SO_MASK = DQ_W'(1 << SO_LANE);

  // Pin synchronizer: {chip select, serial clock, lanes}
  logic [PIN_W-1:0] pins_s;
  logic             csn_s, sck_s;
  logic [DQ_W-1:0]  dq_s;

  sflash_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({csn_i, sck_i, dq_i}),
    .q_o  (pins_s)
  );

  assign csn_s = pins_s[PIN_W-1];
  assign sck_s = pins_s[PIN_W-2];
  assign dq_s  = pins_s[DQ_W-1:0];

  // State
  logic              sck_d_q, csn_d_q, armed_q;
  xfer_phase_e       phase_q, phase_d;
  logic              quad_q, quad_d, first_q, first_d;
  logic              rx_valid_q, rx_valid_d, rx_first_q, rx_first_d;
  logic [BYTE_W-1:0] rx_byte_q, rx_byte_d;
  logic              tx_req_q;
  logic [DQ_W-1:0]   oe_q, oe_d;
  logic              lock_q, lock_d;
  logic              armed_d;

  // Edge and condition decode
  logic rise, fall, cs_fall, clr, active, hold_act, step_in, step_out;
  logic rx_done, tx_load;
  logic [BYTE_W-1:0] rx_shift_byte;

  assign rise     = sck_s & ~sck_d_q;
  assign fall     = ~sck_s & sck_d_q;
  assign cs_fall  = ~csn_s & csn_d_q;
  assign clr      = csn_s | ~armed_q;
  assign active   = ~clr;
  assign hold_act = active & ~quad_en_i & ~dq_s[HOLD_LANE];
  assign step_in  = active & ~hold_act & rise & (phase_q == PH_IN);
  assign step_out = active & ~hold_act & fall & (phase_q == PH_OUT);

  sflash_rx_shift #(
    .BYTE_W(BYTE_W),
    .LANES (DQ_W)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .step_i (step_in),
    .quad_i (quad_q),
    .lanes_i(dq_s),
    .done_o (rx_done),
    .byte_o (rx_shift_byte)
  );

  sflash_tx_shift #(
    .BYTE_W (BYTE_W),
    .LANES  (DQ_W),
    .SO_LANE(SO_LANE)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .step_i (step_out),
    .quad_i (quad_q),
    .data_i (tx_data_i),
    .load_o (tx_load),
    .lanes_o(dq_o)
  );

  // Next-state logic
  always_comb begin
    armed_d    = armed_q | cs_fall;
    phase_d    = phase_q;
    quad_d     = quad_q;
    first_d    = first_q;
    rx_valid_d = 1'b0;
    rx_byte_d  = rx_byte_q;
    rx_first_d = rx_first_q;
    if (clr) begin
      phase_d = PH_IN;
      quad_d  = 1'b0;
      first_d = 1'b1;
    end else if (rx_done) begin
      rx_valid_d = 1'b1;
      rx_byte_d  = rx_shift_byte;
      rx_first_d = first_q;
      first_d    = 1'b0;
      if (ph_quad_i && !quad_en_i) begin
        phase_d = PH_DROP;
      end else begin
        quad_d  = ph_quad_i;
        phase_d = ph_out_i ? PH_OUT : PH_IN;
      end
    end
    if (active && !hold_act && phase_q == PH_OUT) begin
      oe_d = quad_q ? '1 : SO_MASK;
    end else begin
      oe_d = '0;
    end
    lock_d = srp_i & ~quad_en_i & ~dq_s[WP_LANE];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q    <= 1'b0;
      csn_d_q    <= 1'b0;
      armed_q    <= 1'b0;
      phase_q    <= PH_IN;
      quad_q     <= 1'b0;
      first_q    <= 1'b1;
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
      rx_first_q <= 1'b0;
      tx_req_q   <= 1'b0;
      oe_q       <= '0;
      lock_q     <= 1'b0;
    end else begin
      sck_d_q    <= sck_s;
      csn_d_q    <= csn_s;
      armed_q    <= armed_d;
      phase_q    <= phase_d;
      quad_q     <= quad_d;
      first_q    <= first_d;
      rx_valid_q <= rx_valid_d;
      if (rx_valid_d) begin
        rx_byte_q  <= rx_byte_d;
        rx_first_q <= rx_first_d;
      end
      tx_req_q   <= tx_load;
      oe_q       <= oe_d;
      lock_q     <= lock_d;
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
  assign rx_first_o = rx_first_q;
  assign tx_req_o   = tx_req_q;
  assign dq_oe_o    = oe_q;
  assign sr_lock_o  = lock_q;

  // Assertions
  // R6: no byte is delivered before chip select has been armed by a falling edge
  a_r6_rx_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> armed_q);

  // R2: four-bit mode is only entered while quad-enable is set
  a_r2_quad_needs_qe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quad_q) |-> $past(quad_en_i));

  // R3: a dropped transaction produces neither strobes nor enables
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DROP) |=> (!rx_valid_o && dq_oe_o == '0));

  // R4: output lanes move only after a falling edge or an abort
  a_r4_dq_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_o) |-> $past(step_out || clr));

  // R5: enable pattern is one of the three legal shapes
  a_r5_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o == '0) || (dq_oe_o == SO_MASK) || (&dq_oe_o));

  // R5: no lane is enabled once chip select has been high for a cycle
  a_r5_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> (dq_oe_o == '0));

  // R8: hold freezes the output lanes, drops enables and stops strobes
  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |=> ($stable(dq_o) && !rx_valid_o && dq_oe_o == '0));

endmodule

// File: tb/sflash_pin_front_test.sv
`timescale 1ns/1ps
module sflash_pin_front_test;

  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  always #2.5 clk = ~clk;

  logic       csn, sck, din, hold_n, wp_n, drive_quad;
  logic [3:0] nib;
  logic [3:0] dq_in;
  logic       qe, srp, ph_quad, ph_out;
  logic [7:0] tx_data;

  logic [3:0] dq_o, dq_oe_o;
  logic [7:0] rx_byte_o;
  logic       rx_valid_o, rx_first_o, tx_req_o, sr_lock_o;

  assign dq_in = drive_quad ? nib : {hold_n, wp_n, 1'b0, din};

  sflash_pin_front uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_i     (csn),
    .sck_i     (sck),
    .dq_i      (dq_in),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .quad_en_i (qe),
    .srp_i     (srp),
    .ph_quad_i (ph_quad),
    .ph_out_i  (ph_out),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .rx_first_o(rx_first_o),
    .tx_data_i (tx_data),
    .tx_req_o  (tx_req_o),
    .sr_lock_o (sr_lock_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];
  int tx_loads = 0;
  int cs_hi    = 0;
  int oe_viol  = 0;

  // Per-clock reference observations
  always @(negedge clk) begin
    if (rx_valid_o) got_q.push_back({rx_first_o, rx_byte_o});
    if (tx_req_o) begin
      tx_loads = tx_loads + 1;
      tx_data  = tx_data + 8'h11;
    end
    if (csn) cs_hi = cs_hi + 1; else cs_hi = 0;
    if (cs_hi >= 4 && dq_oe_o != 4'h0) oe_viol = oe_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit quad);
    drive_quad = quad;
    for (int k = 0; k < n; k++) begin
      sck = 1'b0;
      if (quad) nib = b[7-4*k -: 4];
      else      din = b[7-k];
      half();
      sck = 1'b1;
      half();
    end
    drive_quad = 1'b0;
  endtask

  task automatic recv_bits(input int n, input bit quad,
                           output logic [7:0] v, output bit oe_ok);
    v = 8'h00;
    oe_ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      sck = 1'b0;
      half();
      if (quad) v = {v[3:0], dq_o};
      else      v = {v[6:0], dq_o[1]};
      if (dq_oe_o != (quad ? 4'hF : 4'b0010)) oe_ok = 1'b0;
      sck = 1'b1;
      half();
    end
  endtask

  task automatic cs_begin();
    csn = 1'b0;
    half();
  endtask

  task automatic cs_end();
    sck = 1'b0;
    half();
    csn = 1'b1;
    half();
    half();
  endtask

  task automatic check_rx(input string req);
    chk(got_q.size() == exp_q.size(), req, "received byte count",
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, "received {first,byte}",
          int'(got_q[i]), int'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    bit ok, ok2;
    int loads0;

    rst_n = 1'b0; csn = 1'b0; sck = 1'b0; din = 1'b0; nib = 4'h0;
    hold_n = 1'b1; wp_n = 1'b1; drive_quad = 1'b0;
    qe = 1'b0; srp = 1'b0; ph_quad = 1'b0; ph_out = 1'b0; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state (R5, R10)
    chk(dq_oe_o == 4'h0, "R5", "oe after reset", dq_oe_o, 0);
    chk(rx_valid_o == 1'b0 && tx_req_o == 1'b0, "R1", "strobes after reset",
        {rx_valid_o, tx_req_o}, 0);
    chk(sr_lock_o == 1'b0, "R10", "lock after reset", sr_lock_o, 0);

    // R6: chip select low since reset, never seen falling
    send_bits(8'hAB, 8, 1'b0);
    sck = 1'b0; half();
    check_rx("R6");
    csn = 1'b1; half(); half();

    // R1: one-bit stream, first flag on instruction only
    cs_begin();
    send_bits(8'h9F, 8, 1'b0);
    send_bits(8'h3C, 8, 1'b0);
    cs_end();
    exp_q.push_back({1'b1, 8'h9F});
    exp_q.push_back({1'b0, 8'h3C});
    check_rx("R1");

    // R7: partial byte aborted, fresh transaction follows
    cs_begin();
    send_bits(8'hF0, 4, 1'b0);
    cs_end();
    cs_begin();
    send_bits(8'h5A, 8, 1'b0);
    cs_end();
    exp_q.push_back({1'b1, 8'h5A});
    check_rx("R7");

    // R2: width switch to nibbles after instruction
    qe = 1'b1; ph_quad = 1'b1;
    cs_begin();
    send_bits(8'h6B, 8, 1'b0);
    send_bits(8'hA5, 2, 1'b1);
    send_bits(8'h0F, 2, 1'b1);
    cs_end();
    exp_q.push_back({1'b1, 8'h6B});
    exp_q.push_back({1'b0, 8'hA5});
    exp_q.push_back({1'b0, 8'h0F});
    check_rx("R2");

    // R9: quad-enable set, hold and write-protect pins low have no effect
    ph_quad = 1'b0; srp = 1'b1; hold_n = 1'b0; wp_n = 1'b0;
    cs_begin();
    send_bits(8'hC6, 8, 1'b0);
    cs_end();
    exp_q.push_back({1'b1, 8'hC6});
    check_rx("R9");
    chk(sr_lock_o == 1'b0, "R9", "lock with quad-enable set", sr_lock_o, 0);
    hold_n = 1'b1; wp_n = 1'b1; srp = 1'b0;

    // R3: four-bit request with quad-enable clear is dropped
    qe = 1'b0; ph_quad = 1'b1; ph_out = 1'b1;
    cs_begin();
    send_bits(8'hEB, 8, 1'b0);
    send_bits(8'hFF, 2, 1'b1);
    sck = 1'b0; half();
    chk(dq_oe_o == 4'h0, "R3", "oe in dropped transaction", dq_oe_o, 0);
    send_bits(8'hFF, 2, 1'b1);
    cs_end();
    exp_q.push_back({1'b1, 8'hEB});
    check_rx("R3");
    ph_quad = 1'b0; ph_out = 1'b0;

    // R4/R5: one-bit read
    tx_data = 8'hC3; loads0 = tx_loads;
    ph_out = 1'b1;
    cs_begin();
    send_bits(8'h03, 8, 1'b0);
    recv_bits(8, 1'b0, v, ok);
    chk(v == 8'hC3, "R4", "one-bit read byte 0", v, 8'hC3);
    chk(ok, "R5", "one-bit read enable pattern", 0, 1);
    recv_bits(8, 1'b0, v, ok);
    chk(v == 8'hD4, "R4", "one-bit read byte 1", v, 8'hD4);
    chk(tx_loads - loads0 == 2, "R4", "tx_req pulses", tx_loads - loads0, 2);
    cs_end();
    ph_out = 1'b0;
    chk(dq_oe_o == 4'h0, "R5", "oe after deselect", dq_oe_o, 0);
    exp_q.push_back({1'b1, 8'h03});
    check_rx("R4");

    // R4/R5: four-bit read
    qe = 1'b1; ph_quad = 1'b1; ph_out = 1'b1; tx_data = 8'h96;
    cs_begin();
    send_bits(8'hEB, 8, 1'b0);
    recv_bits(2, 1'b1, v, ok);
    chk(v == 8'h96, "R4", "four-bit read byte 0", v, 8'h96);
    chk(ok, "R5", "four-bit read enable pattern", 0, 1);
    recv_bits(2, 1'b1, v, ok);
    chk(v == 8'hA7, "R4", "four-bit read byte 1", v, 8'hA7);
    cs_end();
    exp_q.push_back({1'b1, 8'hEB});
    check_rx("R2");
    qe = 1'b0; ph_quad = 1'b0; ph_out = 1'b0;

    // R8: hold mid-byte during input
    cs_begin();
    send_bits(8'hB7, 3, 1'b0);
    hold_n = 1'b0; half();
    send_bits(8'h00, 3, 1'b0);
    hold_n = 1'b1; half();
    send_bits(8'hB7 << 3, 5, 1'b0);
    cs_end();
    exp_q.push_back({1'b1, 8'hB7});
    check_rx("R8");

    // R8: hold mid-byte during output
    ph_out = 1'b1; tx_data = 8'h5E;
    cs_begin();
    send_bits(8'h0B, 8, 1'b0);
    recv_bits(3, 1'b0, v, ok);
    hold_n = 1'b0; half();
    chk(dq_oe_o == 4'h0, "R8", "oe during hold", dq_oe_o, 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b0; half(); sck = 1'b1; half();
    end
    hold_n = 1'b1; half();
    recv_bits(5, 1'b0, v2, ok2);
    chk(((v << 5) | v2) == 8'h5E, "R8", "read resumed after hold",
        (v << 5) | v2, 8'h5E);
    chk(ok && ok2, "R8", "oe restored after hold", 0, 1);
    cs_end();
    ph_out = 1'b0;
    exp_q.push_back({1'b1, 8'h0B});
    check_rx("R8");

    // R10: lock flag over protect inputs
    qe = 1'b0; srp = 1'b1; wp_n = 1'b0; repeat (6) @(negedge clk);
    chk(sr_lock_o == 1'b1, "R10", "lock srp=1 wp low", sr_lock_o, 1);
    wp_n = 1'b1; repeat (6) @(negedge clk);
    chk(sr_lock_o == 1'b0, "R10", "lock srp=1 wp high", sr_lock_o, 0);
    srp = 1'b0; wp_n = 1'b0; repeat (6) @(negedge clk);
    chk(sr_lock_o == 1'b0, "R10", "lock srp=0 wp low", sr_lock_o, 0);
    wp_n = 1'b1;

    chk(oe_viol == 0, "R5", "clocks with oe while deselected", oe_viol, 0);

    summary();
    $finish;
  end

endmodule